// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block is the register side of a general-purpose I/O port. It stores, for each pin, an output data bit, a direction bit, a pull-disable bit, a sleep-hold bit and two function-select bits. From these it drives the pad ring directly: output enable, output level, pull enable, pull polarity and a two-bit function code per pin. Software reaches it through a small word-indexed register interface with a one-cycle registered read.

Output data and direction are never written as whole words. Each has a set alias and a clear alias: a 1 in a written word changes the matching bit, and a 0 leaves it alone. Several agents can therefore flip their own pins without a read-modify-write. There is no separate pull polarity register. An input pin with its pull on takes its pull direction from its output data bit. While the chip-level sleep request is high, every pin whose sleep-hold bit is 0 is turned into a pulled input. Pad levels come back through a two-flop synchronizer and can be read at their own index.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is a GPIO input (pad_oe = 0, pad_func = 0). The data latch is 0, so pad_out = 0 and pad_pull_up = 0. Pulls are on (pad_pull_en all 1). The direction, pull-disable, sleep-hold and both select registers read 0.
- R2: A write to index 1 (data set) sets each data bit whose written bit is 1 and leaves the bits written 0 unchanged. pad_out shows the data latch.
- R3: A write to index 2 (data clear) clears each data bit whose written bit is 1 and leaves the bits written 0 unchanged.
- R4: Index 4 (direction set) and index 5 (direction clear) change the direction register under the same write-one rule. A direction bit of 1 makes pad_oe 1 for that pin, outside forced sleep.
- R5: Index 8 holds the A-select bits and index 9 the B-select bits. For pin i, pad_func[2i+1:2i] = {B[i], A[i]}, so 00 is GPIO, 01 is function A, 10 is function B and 11 is function C.
- R6: Index 6 is pull-disable. Outside forced sleep, pad_pull_en[i] = 1 only when pin i is an input and its pull-disable bit is 0. pad_pull_up[i] always equals data bit i (1 = up, 0 = down). No pin ever has pad_pull_en and pad_oe both 1.
- R7: Index 7 is sleep-hold. While sleep_req = 1, a pin whose sleep-hold bit is 0 has pad_oe = 0 and pad_pull_en = 1, whatever its pull-disable bit. A pin whose bit is 1 keeps its configured outputs.
- R8: A read of index 0 returns pad_in after a two-flop synchronizer. A read whose capture edge falls one clock after pad_in changes still returns the old level.
- R9: A read of index 3 returns the direction register. Indices 6 to 9 read back what was written. The aliases (1, 2, 4, 5) and unmapped indices read 0. Writes to index 0 or to an unmapped index change nothing.
- R10: bus_rdata is loaded at the clock edge where bus_rd = 1 and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, data valid the next cycle |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Registered read data |
| sleep_req | input | 1 | Chip-level sleep request |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin output level |
| pad_pull_en | output | NUM_PINS | Per-pin pull enable |
| pad_pull_up | output | NUM_PINS | Per-pin pull polarity, 1 = up |
| pad_func | output | 2*NUM_PINS | Per-pin function code {B, A} |

## Verification
The bench builds the block with its defaults: 32 pins and a 4-bit index. At that width every bit of every register and every pad vector is exercised by 32-bit random masks, and the full index space, with its unmapped entries, can be swept. A striped pattern of select bits puts all four function codes on the pins at once. A pad change placed one cycle before a read capture covers the synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_PADIN  = 4'd0,
    IDX_DSET   = 4'd1,
    IDX_DCLR   = 4'd2,
    IDX_DIR    = 4'd3,
    IDX_DIRSET = 4'd4,
    IDX_DIRCLR = 4'd5,
    IDX_PDIS   = 4'd6,
    IDX_SLP    = 4'd7,
    IDX_SELA   = 4'd8,
    IDX_SELB   = 4'd9
  } reg_idx_e;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_A    = 2'b01,
    FN_B    = 2'b10,
    FN_C    = 2'b11
  } func_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  assign q_en = set_en | clr_en;

  always_comb begin
    q_nxt = q;
    if (set_en) begin
      q_nxt = q | mask;
    end else if (clr_en) begin
      q_nxt = q & ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  // R2 and R4: a set write raises every masked bit and leaves the others.
  p_set_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (((q & $past(mask)) == $past(mask)) &&
                ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

  // R3 and R4: a clear write drops every masked bit and leaves the others.
  p_clr_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (((q & $past(mask)) == '0) &&
                ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

  // R4: with no write the register holds.
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_in;
      d_sync <= meta_q;
    end
  end

  // R8: the output stage follows the first stage one clock later.
  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (d_sync == $past(meta_q)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                  sleep_req,
  input  logic [NUM_PINS-1:0]   data_q,
  input  logic [NUM_PINS-1:0]   dir_q,
  input  logic [NUM_PINS-1:0]   pdis_q,
  input  logic [NUM_PINS-1:0]   slp_q,
  input  logic [NUM_PINS-1:0]   sela_q,
  input  logic [NUM_PINS-1:0]   selb_q,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_pull_en,
  output logic [NUM_PINS-1:0]   pad_pull_up,
  output logic [2*NUM_PINS-1:0] pad_func
);

  import gpio_bank_pkg::*;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic  forced_in;
    func_e code;

    assign forced_in      = sleep_req & ~slp_q[i];
    assign code           = func_e'({selb_q[i], sela_q[i]});
    assign pad_oe[i]      = dir_q[i] & ~forced_in;
    assign pad_pull_en[i] = forced_in | (~dir_q[i] & ~pdis_q[i]);
    assign pad_out[i]     = data_q[i];
    assign pad_pull_up[i] = data_q[i];
    assign pad_func[2*i +: 2] = code;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NUM_PINS-1:0]   bus_wdata,
  output logic [NUM_PINS-1:0]   bus_rdata,
  input  logic                  sleep_req,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_pull_en,
  output logic [NUM_PINS-1:0]   pad_pull_up,
  output logic [2*NUM_PINS-1:0] pad_func
);

  import gpio_bank_pkg::*;

  localparam logic [ADDR_W-1:0] A_PADIN  = ADDR_W'(IDX_PADIN);
  localparam logic [ADDR_W-1:0] A_DSET   = ADDR_W'(IDX_DSET);
  localparam logic [ADDR_W-1:0] A_DCLR   = ADDR_W'(IDX_DCLR);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(IDX_DIR);
  localparam logic [ADDR_W-1:0] A_DIRSET = ADDR_W'(IDX_DIRSET);
  localparam logic [ADDR_W-1:0] A_DIRCLR = ADDR_W'(IDX_DIRCLR);
  localparam logic [ADDR_W-1:0] A_PDIS   = ADDR_W'(IDX_PDIS);
  localparam logic [ADDR_W-1:0] A_SLP    = ADDR_W'(IDX_SLP);
  localparam logic [ADDR_W-1:0] A_SELA   = ADDR_W'(IDX_SELA);
  localparam logic [ADDR_W-1:0] A_SELB   = ADDR_W'(IDX_SELB);

  logic                rst_q_n;
  logic [NUM_PINS-1:0] data_q, dir_q, pdis_q, slp_q, sela_q, selb_q;
  logic [NUM_PINS-1:0] pdis_nxt, slp_nxt, sela_nxt, selb_nxt;
  logic                pdis_en, slp_en, sela_en, selb_en;
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] rd_nxt;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_data (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_en (bus_wr && (bus_addr == A_DSET)),
    .clr_en (bus_wr && (bus_addr == A_DCLR)),
    .mask   (bus_wdata),
    .q      (data_q)
  );

  gpio_setclr_reg #(.WIDTH(NUM_PINS)) u_dir (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_en (bus_wr && (bus_addr == A_DIRSET)),
    .clr_en (bus_wr && (bus_addr == A_DIRCLR)),
    .mask   (bus_wdata),
    .q      (dir_q)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .d_in   (pad_in),
    .d_sync (pad_sync)
  );

  // Plain configuration registers: next state and enables.
  always_comb begin
    pdis_en  = bus_wr && (bus_addr == A_PDIS);
    slp_en   = bus_wr && (bus_addr == A_SLP);
    sela_en  = bus_wr && (bus_addr == A_SELA);
    selb_en  = bus_wr && (bus_addr == A_SELB);
    pdis_nxt = bus_wdata;
    slp_nxt  = bus_wdata;
    sela_nxt = bus_wdata;
    selb_nxt = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pdis_q <= '0;
      slp_q  <= '0;
      sela_q <= '0;
      selb_q <= '0;
    end else begin
      if (pdis_en) pdis_q <= pdis_nxt;
      if (slp_en)  slp_q  <= slp_nxt;
      if (sela_en) sela_q <= sela_nxt;
      if (selb_en) selb_q <= selb_nxt;
    end
  end

  // Read path.
  always_comb begin
    unique case (bus_addr)
      A_PADIN: rd_nxt = pad_sync;
      A_DIR:   rd_nxt = dir_q;
      A_PDIS:  rd_nxt = pdis_q;
      A_SLP:   rd_nxt = slp_q;
      A_SELA:  rd_nxt = sela_q;
      A_SELB:  rd_nxt = selb_q;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_nxt;
    end
  end

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pads (
    .sleep_req   (sleep_req),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .pdis_q      (pdis_q),
    .slp_q       (slp_q),
    .sela_q      (sela_q),
    .selb_q      (selb_q),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up),
    .pad_func    (pad_func)
  );

  // R6: a pin never drives and pulls at the same time.
  p_pull_vs_drive_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((pad_pull_en & pad_oe) == '0));

  // R7: in sleep, pins without the hold bit are undriven.
  p_sleep_release_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleep_req |-> ((pad_oe & ~slp_q) == '0));

  // R9: alias indices read back as zero.
  p_alias_zero_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_rd && ((bus_addr == A_DSET) || (bus_addr == A_DCLR) ||
                (bus_addr == A_DIRSET) || (bus_addr == A_DIRCLR)))
    |=> (bus_rdata == '0));

  // R10: read data holds without a read strobe.
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

  localparam int N  = 32;
  localparam int AW = 4;

  logic          clk;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata, bus_rdata;
  logic          sleep_req;
  logic [N-1:0]  pad_in;
  logic [N-1:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic [2*N-1:0] pad_func;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [N-1:0] m_data, m_dir, m_pdis, m_slp, m_sela, m_selb;

  gpio_bank #(.NUM_PINS(N), .ADDR_W(AW)) u0 (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .sleep_req, .pad_in, .pad_oe, .pad_out, .pad_pull_en, .pad_pull_up,
    .pad_func
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] e_forced();
    return sleep_req ? ~m_slp : '0;
  endfunction
  function automatic logic [N-1:0] e_oe();
    return m_dir & ~e_forced();
  endfunction
  function automatic logic [N-1:0] e_pull();
    return e_forced() | (~m_dir & ~m_pdis);
  endfunction
  function automatic logic [2*N-1:0] e_func();
    logic [2*N-1:0] f;
    for (int i = 0; i < N; i++) f[2*i +: 2] = {m_selb[i], m_sela[i]};
    return f;
  endfunction

  task automatic check_pads(input string req);
    chk(pad_oe == e_oe(), {req, " oe"}, 64'(pad_oe), 64'(e_oe()));
    chk(pad_out == m_data, {req, " out"}, 64'(pad_out), 64'(m_data));
    chk(pad_pull_en == e_pull(), {req, " pull_en"}, 64'(pad_pull_en), 64'(e_pull()));
    chk(pad_pull_up == m_data, {req, " pull_up"}, 64'(pad_pull_up), 64'(m_data));
    chk(pad_func == e_func(), {req, " func"}, pad_func, e_func());
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'd1: m_data = m_data | d;
      4'd2: m_data = m_data & ~d;
      4'd4: m_dir  = m_dir | d;
      4'd5: m_dir  = m_dir & ~d;
      4'd6: m_pdis = d;
      4'd7: m_slp  = d;
      4'd8: m_sela = d;
      4'd9: m_selb = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [N-1:0] e_read(input logic [AW-1:0] a);
    case (a)
      4'd3: return m_dir;
      4'd6: return m_pdis;
      4'd7: return m_slp;
      4'd8: return m_sela;
      4'd9: return m_selb;
      default: return '0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] r, old_pad, hold;
    void'($urandom(32'h5eed_0042));
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    sleep_req = 0; pad_in = '0; rst_n = 0;
    m_data = '0; m_dir = '0; m_pdis = '0; m_slp = '0; m_sela = '0; m_selb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_pads("R1");
    chk(pad_pull_en == '1, "R1 pulls on", 64'(pad_pull_en), 64'hffff_ffff);
    for (int a = 3; a <= 9; a++) begin
      if (a == 4 || a == 5) continue;
      rd(AW'(a), r);
      chk(r == '0, "R1 readback", 64'(r), 64'd0);
    end

    // R2 / R3 directed: zero bits keep the latch
    wr(4'd1, 32'h0000_00F0);
    chk(pad_out == 32'h0000_00F0, "R2 set", 64'(pad_out), 64'h0000_00F0);
    wr(4'd1, 32'h0000_0000);
    chk(pad_out == 32'h0000_00F0, "R2 zero set", 64'(pad_out), 64'h0000_00F0);
    wr(4'd2, 32'h0000_0030);
    chk(pad_out == 32'h0000_00C0, "R3 clear", 64'(pad_out), 64'h0000_00C0);

    // R4 direction
    wr(4'd4, 32'h8000_0001);
    chk(pad_oe == 32'h8000_0001, "R4 dir set", 64'(pad_oe), 64'h8000_0001);
    wr(4'd5, 32'h0000_0001);
    chk(pad_oe == 32'h8000_0000, "R4 dir clear", 64'(pad_oe), 64'h8000_0000);
    rd(4'd3, r);
    chk(r == 32'h8000_0000, "R9 dir read", 64'(r), 64'h8000_0000);

    // R5 all four codes
    wr(4'd8, 32'hAAAA_AAAA);
    wr(4'd9, 32'hCCCC_CCCC);
    for (int i = 0; i < N; i++)
      chk(pad_func[2*i +: 2] == 2'(i % 4), "R5 code", 64'(pad_func[2*i +: 2]), 64'(i % 4));

    // R6 pull polarity from data latch, pull only on inputs
    wr(4'd6, 32'h0000_000F);
    check_pads("R6");

    // R7 sleep
    wr(4'd4, 32'hFFFF_0000);
    wr(4'd7, 32'h00FF_00FF);
    @(negedge clk); sleep_req = 1'b1;
    #1 check_pads("R7");
    @(negedge clk); sleep_req = 1'b0;
    #1 check_pads("R7 wake");

    // R9 writes to index 0 and unmapped ignored, unmapped/alias read zero
    wr(4'd0, '1);
    wr(4'd15, '1);
    check_pads("R9 ignored write");
    for (int a = 1; a < 16; a++) begin
      rd(AW'(a), r);
      chk(r == e_read(AW'(a)), "R9 read", 64'(r), 64'(e_read(AW'(a))));
    end

    // R8 synchronizer latency
    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    old_pad = pad_in;
    pad_in = 32'hCAFE_F00D;
    rd(4'd0, r);
    chk(r == old_pad, "R8 old level", 64'(r), 64'(old_pad));
    rd(4'd0, r);
    chk(r == 32'hCAFE_F00D, "R8 new level", 64'(r), 64'hCAFE_F00D);

    // R10 hold without read
    hold = bus_rdata;
    @(negedge clk); bus_addr = 4'd3;
    repeat (2) @(negedge clk);
    chk(bus_rdata == hold, "R10 hold", 64'(bus_rdata), 64'(hold));

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [N-1:0] d;
      op = int'($urandom % 10);
      d  = $urandom;
      case (op)
        0: wr(4'd1, d);
        1: wr(4'd2, d);
        2: wr(4'd4, d);
        3: wr(4'd5, d);
        4: wr(4'd6, d);
        5: wr(4'd7, d);
        6: wr(4'd8, d);
        7: wr(4'd9, d);
        8: begin
          logic [AW-1:0] a;
          a = AW'($urandom % 16);
          if (a != 0) begin
            rd(a, r);
            chk(r == e_read(a), "R9 random read", 64'(r), 64'(e_read(a)));
          end
        end
        default: begin
          @(negedge clk); pad_in = d; sleep_req = $urandom % 2;
          repeat (3) @(negedge clk);
          rd(4'd0, r);
          chk(r == d, "R8 random pad", 64'(r), 64'(d));
        end
      endcase
      #1 check_pads("R2 R3 R4 R6 R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule